// File: doc/BRIEF.md
# Multi-Station Task Allocator

This block sits between a set of simultaneous task inputs and a pool of processing stations. In every cycle it looks at up to three incoming task codes and at one ready bit per station. It hands each task to a station that is free and able to process that task type, and places at most one task on any station. A station that gets nothing sees code 0. A single flag tells the surrounding logic that some real task could not be placed. A small count reports how many tasks were placed in the cycle, so that an external tally can be kept.

The placement is greedy and deterministic. Tasks are handled from the lowest input index upward. Each task takes the free, capable station with the fewest processing cycles for its type. If two stations tie, the lower station index wins. The cost table is built in and depends on whether two or four task types are configured. The results are registered, so they are valid one cycle after the inputs are presented.

Top module: `task_allocator`

## Requirements
- R1: While `rst` is high at a rising edge, every allocation field, `reject_flag` and `placed_cnt` become 0 at that edge, whatever the inputs.
- R2: All outputs are registered. The values after rising edge k describe the inputs that were present just before edge k. Between edges the outputs do not change.
- R3: A task code of 0 means no task. It is never placed and never raises `reject_flag`. Codes above `N_TYPES` are illegal, and the outputs they produce are not specified.
- R4: A station only receives types it can process. Processing cycles per (station, type) are as follows. With four types: station 0 takes 1,2,3,4; station 1 takes 2,1,2,3; station 2 takes 1,1,1,1; station 3 takes 2,2 and cannot process types 3 or 4. With two types: station 0 takes 1,2; station 1 takes 3,1; station 2 takes 1,1; station 3 takes 2,2.
- R5: A station whose ready bit was 0 receives code 0.
- R6: Each station receives at most one task per cycle, and each task goes to at most one station. A station given no task receives code 0.
- R7: Tasks are placed in input index order. Input 0 chooses first, and a later input only sees the stations left over by earlier ones.
- R8: Among the ready, capable, still unused stations, a task takes the one with the fewest processing cycles for its type. A tie goes to the lower station index.
- R9: `reject_flag` is 1 exactly when at least one legal nonzero task input was left unplaced.
- R10: `placed_cnt` equals the number of tasks placed, which is also the number of stations with a nonzero allocation.
- R11: Task input i occupies bits [i*W +: W] of `task_in`, and the allocation for station s occupies bits [s*W +: W] of `alloc`. Here W = ceil(log2(N_TYPES+1)), which is 3 for four types and 2 for two types. Code t in 1..N_TYPES is task type t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| task_in | input | N_IN*W | Packed task codes, input 0 in the low field |
| ready | input | N_ST | One ready bit per station |
| alloc | output | N_ST*W | Packed task code given to each station, station 0 in the low field |
| reject_flag | output | 1 | Some legal nonzero task was not placed |
| placed_cnt | output | clog2(N_IN+1) | Number of tasks placed |

## Verification
Every output of this block is due exactly one rising edge after its inputs are presented. The bench therefore drives the tasks and ready bits on a falling edge and compares the outputs on the next falling edge, after one rising edge has passed. Just after driving a new vector, it also confirms that the outputs still show the previous vector's results, which checks the one-cycle latency. Expected values come from a greedy model of the placement rules and cost tables in the bench. This model is swept over every legal task combination and every ready pattern, for both the four-type configuration and a two-type, two-input, two-station configuration.

// File: rtl/task_sched_pkg.sv
`timescale 1ns/1ps
package task_sched_pkg;

    localparam int unsigned DEF_TYPES    = 4;
    localparam int unsigned DEF_INPUTS   = 3;
    localparam int unsigned DEF_STATIONS = 4;
    localparam int unsigned COST_W       = 4;

    typedef logic [COST_W-1:0] cost_t;

    // Per-task outcome of one placement stage
    typedef struct packed {
        logic placed;
        logic missed;
    } stage_res_t;

    function automatic int unsigned code_width(input int unsigned n_types);
        return $clog2(n_types + 1);
    endfunction

    // Processing cycles of type ty on station st; 0 means "cannot process"
    function automatic cost_t proc_cost(input int unsigned n_types,
                                        input int unsigned st,
                                        input int unsigned ty);
        cost_t c;
        c = '0;
        if (ty != 0 && ty <= n_types) begin
            case (st)
                0: c = cost_t'(ty);
                1: begin
                    if (n_types <= 2) c = (ty == 1) ? cost_t'(3) : cost_t'(1);
                    else begin
                        case (ty)
                            1:       c = cost_t'(2);
                            2:       c = cost_t'(1);
                            3:       c = cost_t'(2);
                            default: c = cost_t'(3);
                        endcase
                    end
                end
                2: c = cost_t'(1);
                3: c = (ty <= 2) ? cost_t'(2) : cost_t'(0);
                default: c = '0;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/task_decode.sv
`timescale 1ns/1ps
module task_decode
    import task_sched_pkg::*;
#(
    parameter int unsigned N_TYPES = DEF_TYPES,
    parameter int unsigned CODE_W  = code_width(N_TYPES)
) (
    input  logic [CODE_W-1:0] code,
    output logic              is_task
);
    // Legal, nonzero code; illegal codes are treated as "no task"
    always_comb begin
        is_task = (code != '0) && (int'(code) <= int'(N_TYPES));
    end
endmodule

// File: rtl/station_matcher.sv
`timescale 1ns/1ps
module station_matcher
    import task_sched_pkg::*;
#(
    parameter int unsigned N_TYPES = DEF_TYPES,
    parameter int unsigned N_ST    = DEF_STATIONS,
    parameter int unsigned CODE_W  = code_width(N_TYPES)
) (
    input  logic [CODE_W-1:0] code,
    input  logic              is_task,
    input  logic [N_ST-1:0]   avail_in,
    output logic [N_ST-1:0]   grant,
    output logic [N_ST-1:0]   avail_out,
    output stage_res_t        res
);
    cost_t best;
    cost_t c;
    logic  found;
    int    sel;

    always_comb begin
        best  = '1;
        found = 1'b0;
        sel   = 0;
        for (int s = 0; s < int'(N_ST); s++) begin
            c = proc_cost(N_TYPES, s, int'(code));
            if (is_task && avail_in[s] && (c != '0) && (!found || c < best)) begin
                found = 1'b1;
                best  = c;
                sel   = s;
            end
        end
        grant      = found ? (N_ST'(1) << sel) : '0;
        avail_out  = avail_in & ~grant;
        res.placed = found;
        res.missed = is_task && !found;
    end
endmodule

// File: rtl/placed_counter.sv
`timescale 1ns/1ps
module placed_counter #(
    parameter int unsigned N_IN  = 3,
    parameter int unsigned CNT_W = $clog2(N_IN + 1)
) (
    input  logic [N_IN-1:0]  placed,
    output logic [CNT_W-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < int'(N_IN); i++) begin
            count = count + CNT_W'(placed[i]);
        end
    end
endmodule

// File: rtl/task_allocator.sv
`timescale 1ns/1ps
module task_allocator
    import task_sched_pkg::*;
#(
    parameter int unsigned N_TYPES = DEF_TYPES,
    parameter int unsigned N_IN    = DEF_INPUTS,
    parameter int unsigned N_ST    = DEF_STATIONS,
    localparam int unsigned CODE_W = code_width(N_TYPES),
    localparam int unsigned CNT_W  = $clog2(N_IN + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_IN*CODE_W-1:0] task_in,
    input  logic [N_ST-1:0]        ready,
    output logic [N_ST*CODE_W-1:0] alloc,
    output logic                   reject_flag,
    output logic [CNT_W-1:0]       placed_cnt
);
    logic [CODE_W-1:0] code   [N_IN];
    logic [N_ST-1:0]   avail  [N_IN+1];
    logic [N_ST-1:0]   grant  [N_IN];
    logic [N_IN-1:0]   is_task;
    logic [N_IN-1:0]   placed;
    logic [N_IN-1:0]   missed;
    stage_res_t        res    [N_IN];

    logic [N_ST*CODE_W-1:0] alloc_d;
    logic                   flag_d;
    logic [CNT_W-1:0]       cnt_d;

    assign avail[0] = ready;

    // Chain of placement stages, one per task input, lowest index first
    for (genvar i = 0; i < int'(N_IN); i++) begin : g_stage
        assign code[i] = task_in[i*CODE_W +: CODE_W];

        task_decode #(.N_TYPES(N_TYPES), .CODE_W(CODE_W)) u_dec (
            .code    (code[i]),
            .is_task (is_task[i])
        );

        station_matcher #(.N_TYPES(N_TYPES), .N_ST(N_ST), .CODE_W(CODE_W)) u_match (
            .code      (code[i]),
            .is_task   (is_task[i]),
            .avail_in  (avail[i]),
            .grant     (grant[i]),
            .avail_out (avail[i+1]),
            .res       (res[i])
        );

        assign placed[i] = res[i].placed;
        assign missed[i] = res[i].missed;
    end

    placed_counter #(.N_IN(N_IN), .CNT_W(CNT_W)) u_cnt (
        .placed (placed),
        .count  (cnt_d)
    );

    // Route each granted task code onto its station field
    always_comb begin
        alloc_d = '0;
        for (int s = 0; s < int'(N_ST); s++) begin
            for (int i = 0; i < int'(N_IN); i++) begin
                if (grant[i][s]) alloc_d[s*CODE_W +: CODE_W] = code[i];
            end
        end
        flag_d = |missed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alloc       <= '0;
            reject_flag <= 1'b0;
            placed_cnt  <= '0;
        end else begin
            alloc       <= alloc_d;
            reject_flag <= flag_d;
            placed_cnt  <= cnt_d;
        end
    end
endmodule

// File: rtl/task_allocator_chk.sv
`timescale 1ns/1ps
module task_allocator_chk
    import task_sched_pkg::*;
#(
    parameter int unsigned N_TYPES = DEF_TYPES,
    parameter int unsigned N_IN    = DEF_INPUTS,
    parameter int unsigned N_ST    = DEF_STATIONS,
    localparam int unsigned CODE_W = code_width(N_TYPES),
    localparam int unsigned CNT_W  = $clog2(N_IN + 1)
) (
    input logic                   clk,
    input logic                   rst,
    input logic [N_IN*CODE_W-1:0] task_in,
    input logic [N_ST-1:0]        ready,
    input logic [N_ST*CODE_W-1:0] alloc,
    input logic                   reject_flag,
    input logic [CNT_W-1:0]       placed_cnt
);
    logic [N_ST-1:0] busy_out;

    always_comb begin
        for (int s = 0; s < int'(N_ST); s++) begin
            busy_out[s] = alloc[s*CODE_W +: CODE_W] != '0;
        end
    end

    for (genvar s = 0; s < int'(N_ST); s++) begin : g_st
        // R5: an unready station gets nothing
        a_r5_ready_only: assert property (@(posedge clk) disable iff (rst)
            !$past(ready[s]) |-> alloc[s*CODE_W +: CODE_W] == '0);
        // R4: only capable stations receive a type
        a_r4_capable: assert property (@(posedge clk) disable iff (rst)
            busy_out[s] |-> proc_cost(N_TYPES, s, int'(alloc[s*CODE_W +: CODE_W])) != '0);
    end

    // R10: count agrees with occupied station fields
    a_r10_count_match: assert property (@(posedge clk) disable iff (rst)
        int'(placed_cnt) == $countones(busy_out));

    // R3: no task in, nothing out
    a_r3_idle_input: assert property (@(posedge clk) disable iff (rst)
        $past(task_in) == '0 |-> (!reject_flag && alloc == '0));

    // R9: a rejection needs a pending task
    a_r9_flag_needs_task: assert property (@(posedge clk) disable iff (rst)
        reject_flag |-> $past(task_in) != '0);
endmodule

bind task_allocator task_allocator_chk #(
    .N_TYPES (N_TYPES),
    .N_IN    (N_IN),
    .N_ST    (N_ST)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .task_in     (task_in),
    .ready       (ready),
    .alloc       (alloc),
    .reject_flag (reject_flag),
    .placed_cnt  (placed_cnt)
);

// File: tb/task_allocator_tb.sv
`timescale 1ns/1ps
module task_allocator_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    // Config A: 4 types, 3 inputs, 4 stations (3-bit codes)
    logic [8:0]  task_a  = '0;
    logic [3:0]  ready_a = '0;
    logic [11:0] alloc_a;
    logic        flag_a;
    logic [1:0]  cnt_a;

    // Config B: 2 types, 2 inputs, 2 stations (2-bit codes)
    logic [3:0]  task_b  = '0;
    logic [1:0]  ready_b = '0;
    logic [3:0]  alloc_b;
    logic        flag_b;
    logic [1:0]  cnt_b;

    task_allocator #(.N_TYPES(4), .N_IN(3), .N_ST(4)) u_dut (
        .clk(clk), .rst(rst), .task_in(task_a), .ready(ready_a),
        .alloc(alloc_a), .reject_flag(flag_a), .placed_cnt(cnt_a)
    );

    task_allocator #(.N_TYPES(2), .N_IN(2), .N_ST(2)) u_dut2 (
        .clk(clk), .rst(rst), .task_in(task_b), .ready(ready_b),
        .alloc(alloc_b), .reject_flag(flag_b), .placed_cnt(cnt_b)
    );

    int checks = 0;
    int errors = 0;

    // Cycle tables from R4 (0 = cannot process)
    int lut4 [4][4] = '{'{1,2,3,4}, '{2,1,2,3}, '{1,1,1,1}, '{2,2,0,0}};
    int lut2 [4][2] = '{'{1,2}, '{3,1}, '{1,1}, '{2,2}};

    function automatic int cyc(int nt, int s, int t);
        if (t < 1 || t > nt) return 0;
        return (nt == 4) ? lut4[s][t-1] : lut2[s][t-1];
    endfunction

    // Greedy reference following R6, R7, R8, R9, R10
    task automatic model(input int nt, input int nin, input int nst,
                         input int codes [3], input int rdy,
                         output int ea [4], output int ef, output int ec);
        int avail;
        avail = rdy;
        ef = 0;
        ec = 0;
        for (int s = 0; s < 4; s++) ea[s] = 0;
        for (int i = 0; i < nin; i++) begin
            int sel;
            int best;
            sel = -1;
            best = 0;
            if (codes[i] == 0) continue;
            for (int s = 0; s < nst; s++) begin
                int k;
                k = cyc(nt, s, codes[i]);
                if (avail[s] && k > 0 && (sel < 0 || k < best)) begin
                    sel = s;
                    best = k;
                end
            end
            if (sel >= 0) begin
                ea[sel] = codes[i];
                avail[sel] = 0;
                ec++;
            end else ef = 1;
        end
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int codes [3];
        int ea [4];
        int ef;
        int ec;
        int pa [4];
        int pf;
        int pc;

        // R1: reset holds outputs at zero even with live inputs
        @(negedge clk);
        task_a  = 9'b001_010_001;
        ready_a = 4'hF;
        task_b  = 4'b01_10;
        ready_b = 2'b11;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 alloc A", int'(alloc_a), 0);
        check("R1 flag A", int'(flag_a), 0);
        check("R1 count A", int'(cnt_a), 0);
        check("R1 alloc B", int'(alloc_b), 0);
        task_a  = '0;
        ready_a = '0;
        task_b  = '0;
        ready_b = '0;
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        for (int s = 0; s < 4; s++) pa[s] = 0;
        pf = 0;
        pc = 0;

        // Sweep config A: every legal code triple, every ready pattern
        for (int t0 = 0; t0 <= 4; t0++)
        for (int t1 = 0; t1 <= 4; t1++)
        for (int t2 = 0; t2 <= 4; t2++)
        for (int r = 0; r < 16; r++) begin
            codes[0] = t0; codes[1] = t1; codes[2] = t2;
            task_a  = {3'(t2), 3'(t1), 3'(t0)};
            ready_a = 4'(r);
            #1;
            // R2: nothing changes before the rising edge
            check("R2 hold alloc0", int'(alloc_a[2:0]), pa[0]);
            check("R2 hold flag", int'(flag_a), pf);
            check("R2 hold count", int'(cnt_a), pc);
            model(4, 3, 4, codes, r, ea, ef, ec);
            @(posedge clk);
            @(negedge clk);
            for (int s = 0; s < 4; s++) begin
                check("R3 R4 R5 R6 R7 R8 R11 alloc A",
                      int'((alloc_a >> (3*s)) & 12'h7), ea[s]);
                pa[s] = ea[s];
            end
            check("R9 flag A", int'(flag_a), ef);
            check("R10 count A", int'(cnt_a), ec);
            pf = ef;
            pc = ec;
        end

        // Sweep config B: two-type cost table
        for (int t0 = 0; t0 <= 2; t0++)
        for (int t1 = 0; t1 <= 2; t1++)
        for (int r = 0; r < 4; r++) begin
            codes[0] = t0; codes[1] = t1; codes[2] = 0;
            task_b  = {2'(t1), 2'(t0)};
            ready_b = 2'(r);
            model(2, 2, 2, codes, r, ea, ef, ec);
            @(posedge clk);
            @(negedge clk);
            for (int s = 0; s < 2; s++) begin
                check("R4 R6 R7 R8 R11 alloc B",
                      int'((alloc_b >> (2*s)) & 4'h3), ea[s]);
            end
            check("R9 flag B", int'(flag_b), ef);
            check("R10 count B", int'(cnt_b), ec);
        end

        // R4: types 3 and 4 with only station 3 free are refused
        task_a  = {3'd0, 3'd4, 3'd3};
        ready_a = 4'b1000;
        @(posedge clk);
        @(negedge clk);
        check("R4 station 3 refuses type 3/4", int'(alloc_a), 0);
        check("R4 R9 refusal flag", int'(flag_a), 1);

        // R1: reset asserted mid-run clears outputs
        task_a  = {3'd1, 3'd1, 3'd1};
        ready_a = 4'hF;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 mid-run reset count", int'(cnt_a), 0);
        check("R1 mid-run reset alloc", int'(alloc_a), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule